// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block is a hardware master for a 3-wire serial EEPROM organised as 16-bit words, of the small 93-series kind. A host asks for one of four operations through a single-cycle request: read a word, write a word, allow programming, or forbid programming. The request carries a word address, and a write also carries the 16-bit value to store. The block turns the request into the chip-select, serial-clock and serial-data waveform the memory expects. It samples the memory's serial output and then reports completion with a one-cycle pulse.

Every bit period is split into a clock-low half and a clock-high half. Each half lasts a programmable number of system clocks, so the serial rate is set by a parameter. After a word write, the block briefly deselects the memory, selects it again and watches its data line until the memory signals that programming has finished. If no ready indication arrives within a bounded number of polling intervals, it ends the operation anyway and raises a timeout flag.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Each command starts with an 11-bit header shifted MSB first, formed as 0x180 OR address for read (opcode 10), 0x140 OR address for write (opcode 01), 0x130 for allow-programming and 0x100 for forbid-programming. Command codes on `cmd_i` are 0 read, 1 write, 2 allow, 3 forbid.
- R2: Each serial bit is driven with chip select high and clock low for PHASE_CLKS system clocks, then with clock high for PHASE_CLKS clocks. Data out is held steady while the clock is high, and the clock is never high without chip select.
- R3: A read clocks in 16 bits after the header, MSB first, sampling the memory output at the end of each clock-high half. The zero bit the memory emits during the last header bit never enters the result, and `rdata_o` holds the word when done pulses.
- R4: A write shifts the 16 data bits MSB first right after the header, with the same bit timing.
- R5: After a write's last bit, chip select goes low for one phase and then high with the clock low. The memory output is then checked once per phase, and a high level ends the write with `timeout_o` low.
- R6: If the memory output stays low for POLL_MAX consecutive checks, the write ends with `timeout_o` high. The flag stays set until the next command is accepted, and only a write can set it.
- R7: Allow-programming and forbid-programming send only their 11 header bits, with no data bits and no ready polling.
- R8: Chip select, clock and data out are all low in the cycle `done_o` pulses, and `done_o` is high for exactly one cycle per command.
- R9: `busy_o` is high from the cycle after a request is accepted until done. A request made while busy is ignored and changes neither the wire traffic nor the number of done pulses.
- R10: Synchronous reset, including in the middle of a command, returns the block to idle with `busy_o`, `done_o`, `timeout_o`, the three EEPROM outputs and `rdata_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Command request, taken only while idle |
| cmd_i | input | 2 | Command code: 0 read, 1 write, 2 allow, 3 forbid |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Word to write |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last word read |
| timeout_o | output | 1 | Write ready polling gave up |
| mw_cs_o | output | 1 | EEPROM chip select |
| mw_sk_o | output | 1 | EEPROM serial clock |
| mw_mosi_o | output | 1 | Serial data to the EEPROM |
| mw_miso_i | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach from the ports is the give-up path of ready polling. It needs a memory that never raises its output through thousands of polling intervals. The bench's EEPROM model has a switch that holds the ready level low, and the bench issues one write with that switch on. The short phase length used by the bench keeps the full 4096-interval wait within the run. A second hard case is a request that arrives during a read. The bench injects a conflicting write in the middle of a read, then checks the header the model captured, the target word and the count of done pulses.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [1:0] {
      MW_READ  = 2'd0,
      MW_WRITE = 2'd1,
      MW_WEN   = 2'd2,
      MW_WDS   = 2'd3
   } mw_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LO,
      ST_HI,
      ST_GAP,
      ST_POLL,
      ST_FIN
   } mw_state_e;
endpackage

// File: rtl/mw_phase_tick.sv
module mw_phase_tick #(
   parameter int PHASE_CLKS = 250
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic tick_o
);
   if (PHASE_CLKS < 1) begin : g_bad_phase
      $error("PHASE_CLKS must be at least 1");
   end

   if (PHASE_CLKS == 1) begin : g_every
      assign tick_o = !clr;
   end else begin : g_count
      localparam int CW = $clog2(PHASE_CLKS);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst || clr || tick_o) cnt_q <= '0;
         else                      cnt_q <= cnt_q + CW'(1);
      end

      assign tick_o = !clr && (cnt_q == CW'(PHASE_CLKS - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
         tick_o |=> !tick_o); // R2
   end
endmodule

// File: rtl/mw_poll_count.sv
module mw_poll_count #(
   parameter int POLL_MAX = 4096
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   output logic last_o
);
   if (POLL_MAX < 2) begin : g_bad_poll
      $error("POLL_MAX must be at least 2");
   end

   localparam int PW = $clog2(POLL_MAX);
   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr) cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_q + PW'(1);
   end

   assign last_o = (cnt_q == PW'(POLL_MAX - 1));

   AST_NO_INC_PAST_LAST: assert property (@(posedge clk) disable iff (rst)
      inc |-> !last_o); // R6
endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
   import mw_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int FRAME_W = 11
) (
   input  mw_cmd_e           cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [FRAME_W-1:0] frame_o
);
   localparam int PAD = FRAME_W - 3 - ADDR_W;

   if (PAD < 0) begin : g_bad_frame
      $error("FRAME_W too small for ADDR_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end

   logic [1:0]        op;
   logic [ADDR_W-1:0] fld;

   always_comb begin
      unique case (cmd_i)
         MW_READ:  begin op = 2'b10; fld = addr_i; end
         MW_WRITE: begin op = 2'b01; fld = addr_i; end
         MW_WEN:   begin op = 2'b00; fld = {2'b11, {(ADDR_W-2){1'b0}}}; end
         default:  begin op = 2'b00; fld = '0; end
      endcase
   end

   if (PAD > 0) begin : g_pad
      assign frame_o = {{PAD{1'b0}}, 1'b1, op, fld};
   end else begin : g_nopad
      assign frame_o = {1'b1, op, fld};
   end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
   import mw_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int FRAME_W    = 11,
   parameter int DATA_W     = 16,
   parameter int PHASE_CLKS = 250,
   parameter int POLL_MAX   = 4096
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic [1:0]        cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              timeout_o,
   output logic              mw_cs_o,
   output logic              mw_sk_o,
   output logic              mw_mosi_o,
   input  logic              mw_miso_i
);
   localparam int TOT_W = FRAME_W + DATA_W;
   localparam int CNT_W = $clog2(TOT_W + 1);

   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   mw_state_e         state_q;
   mw_cmd_e           cmd_q;
   mw_cmd_e           cmd_in;
   logic [TOT_W-1:0]  shreg_q;
   logic [CNT_W-1:0]  sent_q;
   logic [CNT_W-1:0]  total_q;
   logic [DATA_W-1:0] rsh_q;
   logic [FRAME_W-1:0] frame;
   logic              tick;
   logic              poll_last;
   logic              poll_inc;
   logic              accept;
   logic              last_bit;

   assign cmd_in = mw_cmd_e'(cmd_i);
   assign accept = (state_q == ST_IDLE) && req_i;
   assign last_bit = (sent_q + CNT_W'(1)) == total_q;

   mw_frame_build #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_frame (
      .cmd_i  (cmd_in),
      .addr_i (addr_i),
      .frame_o(frame)
   );

   mw_phase_tick #(.PHASE_CLKS(PHASE_CLKS)) u_tick (
      .clk   (clk),
      .rst   (rst),
      .clr   (state_q == ST_IDLE),
      .tick_o(tick)
   );

   assign poll_inc = (state_q == ST_POLL) && tick && !mw_miso_i && !poll_last;

   mw_poll_count #(.POLL_MAX(POLL_MAX)) u_poll (
      .clk   (clk),
      .rst   (rst),
      .clr   (state_q != ST_POLL),
      .inc   (poll_inc),
      .last_o(poll_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         cmd_q     <= MW_READ;
         shreg_q   <= '0;
         sent_q    <= '0;
         total_q   <= '0;
         rsh_q     <= '0;
         rdata_o   <= '0;
         timeout_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               cmd_q     <= cmd_in;
               shreg_q   <= {frame, (cmd_in == MW_WRITE) ? wdata_i : {DATA_W{1'b0}}};
               total_q   <= (cmd_in == MW_READ || cmd_in == MW_WRITE) ?
                            CNT_W'(TOT_W) : CNT_W'(FRAME_W);
               sent_q    <= '0;
               timeout_o <= 1'b0;
               state_q   <= ST_LO;
            end
            ST_LO: if (tick) state_q <= ST_HI;
            ST_HI: if (tick) begin
               if (cmd_q == MW_READ && sent_q >= CNT_W'(FRAME_W))
                  rsh_q <= {rsh_q[DATA_W-2:0], mw_miso_i};
               shreg_q <= {shreg_q[TOT_W-2:0], 1'b0};
               sent_q  <= sent_q + CNT_W'(1);
               if (!last_bit)               state_q <= ST_LO;
               else if (cmd_q == MW_WRITE) state_q <= ST_GAP;
               else                         state_q <= ST_FIN;
            end
            ST_GAP: if (tick) state_q <= ST_POLL;
            ST_POLL: if (tick) begin
               if (mw_miso_i) begin
                  state_q <= ST_FIN;
               end else if (poll_last) begin
                  timeout_o <= 1'b1;
                  state_q   <= ST_FIN;
               end
            end
            ST_FIN: begin
               if (cmd_q == MW_READ) rdata_o <= rsh_q;
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign mw_cs_o   = (state_q == ST_LO) || (state_q == ST_HI) || (state_q == ST_POLL);
   assign mw_sk_o   = (state_q == ST_HI);
   assign mw_mosi_o = ((state_q == ST_LO) || (state_q == ST_HI)) && shreg_q[TOT_W-1];

   AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
      mw_sk_o |-> mw_cs_o); // R2
   AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
      (mw_sk_o && $past(mw_sk_o)) |-> $stable(mw_mosi_o)); // R2
   AST_PINS_LOW_AT_DONE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!mw_cs_o && !mw_sk_o && !mw_mosi_o)); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o); // R8
   AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
      (busy_o && $past(busy_o)) |-> $stable(cmd_q)); // R9
   AST_TIMEOUT_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
      $rose(timeout_o) |-> (cmd_q == MW_WRITE)); // R6
endmodule

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;
   localparam int PH = 3;
   localparam int BUSY_CLKS = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req = 1'b0;
   logic [1:0] cmd = 2'd0;
   logic [5:0] addr = 6'd0;
   logic [15:0] wdata = 16'd0;
   logic busy_o, done_o, timeout_o, cs, sk, mosi, miso;
   logic [15:0] rdata_o;

   always #10 clk = ~clk;

   mw_eeprom_ctrl #(.PHASE_CLKS(PH)) dut (
      .clk(clk), .rst(rst), .req_i(req), .cmd_i(cmd), .addr_i(addr),
      .wdata_i(wdata), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
      .timeout_o(timeout_o), .mw_cs_o(cs), .mw_sk_o(sk), .mw_mosi_o(mosi),
      .mw_miso_i(miso)
   );

   int checks = 0;
   int fails = 0;
   int done_cnt = 0;
   int cyc = 0;
   logic [17:0] sb_q[$];

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // ---------------- EEPROM model ----------------
   logic [15:0] mem [64];
   logic [26:0] rx = '0;
   int n = 0;
   logic [1:0] cur_op = 2'd0;
   logic [5:0] cur_addr = 6'd0;
   logic wen_m = 1'b0, dout = 1'b0, wpend = 1'b0, prog = 1'b0, never_ready = 1'b0;
   int prog_cnt = 0;
   logic [10:0] last_frame = '0;
   int seg_edges = 0;
   logic sk_q = 1'b0, cs_q = 1'b0;
   int hi_len = 0, hi_count = 0, timing_bad = 0;
   logic [26:0] next_rx;
   int newn;

   assign next_rx = {rx[25:0], mosi};
   assign newn = n + 1;
   assign miso = prog ? (prog_cnt == 0 && !never_ready) : dout;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i) * 16'h0111;
      mem[0] = 16'hFFFF;
      mem[63] = 16'h8001;
   end

   always @(posedge clk) begin
      if (rst) begin
         n <= 0; dout <= 1'b0; wpend <= 1'b0; prog <= 1'b0;
         sk_q <= 1'b0; cs_q <= 1'b0; hi_len <= 0;
      end else begin
         sk_q <= sk;
         cs_q <= cs;
         if (sk) hi_len <= hi_len + 1;
         if (!sk && sk_q) begin
            hi_count <= hi_count + 1;
            if (hi_len != PH) timing_bad <= timing_bad + 1;
            hi_len <= 0;
         end
         if (cs && sk && !sk_q) begin
            rx <= next_rx;
            n <= newn;
            if (newn == 11) begin
               last_frame <= next_rx[10:0];
               cur_op <= next_rx[7:6];
               cur_addr <= next_rx[5:0];
               dout <= 1'b0;
               if (next_rx[7:6] == 2'b00 && next_rx[5:4] == 2'b11) wen_m <= 1'b1;
               if (next_rx[7:6] == 2'b00 && next_rx[5:4] == 2'b00) wen_m <= 1'b0;
            end
            if (cur_op == 2'b10 && newn > 11 && newn <= 27)
               dout <= mem[cur_addr][27 - newn];
            if (cur_op == 2'b01 && newn == 27) begin
               if (wen_m) mem[cur_addr] <= next_rx[15:0];
               wpend <= 1'b1;
            end
         end
         if (!cs && cs_q) begin
            if (n > 0) seg_edges <= n;
            n <= 0;
            dout <= 1'b0;
            if (wpend) begin
               prog <= 1'b1; prog_cnt <= BUSY_CLKS; wpend <= 1'b0;
            end else if (prog && n == 0) begin
               prog <= 1'b0;
            end
         end else if (prog && prog_cnt != 0) begin
            prog_cnt <= prog_cnt - 1;
         end
      end
   end

   // ---------------- scoreboard monitor ----------------
   always @(negedge clk) begin
      if (!rst && done_o) begin
         logic [17:0] e;
         done_cnt <= done_cnt + 1;
         chk("R8 pins low at done", {cs, sk, mosi}, 3'b000);
         if (sb_q.size() == 0) begin
            chk("R9 unexpected done", 1, 0);
         end else begin
            e = sb_q.pop_front();
            if (e[17]) chk("R3 read word", rdata_o, e[16:1]);
            chk("R6 timeout flag", timeout_o, e[0]);
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual expired expected finish");
         summary();
      end
   end

   function automatic logic [10:0] exp_frame(input logic [1:0] c, input logic [5:0] a);
      case (c)
         2'd0: return 11'h180 | {5'd0, a};
         2'd1: return 11'h140 | {5'd0, a};
         2'd2: return 11'h130;
         default: return 11'h100;
      endcase
   endfunction

   task automatic issue(input logic [1:0] c, input logic [5:0] a, input logic [15:0] d,
                        input logic chk_rd, input logic [15:0] erd, input logic eto);
      @(negedge clk);
      while (busy_o) @(negedge clk);
      sb_q.push_back({chk_rd, erd, eto});
      req = 1'b1; cmd = c; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done();
      int start;
      start = done_cnt;
      while (done_cnt == start) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int d0;
      logic [15:0] keep2;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", busy_o, 0);
      chk("R10 done", done_o, 0);
      chk("R10 timeout", timeout_o, 0);
      chk("R10 pins", {cs, sk, mosi}, 3'b000);
      chk("R10 rdata", rdata_o, 16'h0);
      rst = 1'b0;

      // R7 allow programming
      issue(2'd2, 6'd0, 16'h0, 1'b0, 16'h0, 1'b0);
      chk("R9 busy after accept", busy_o, 1);
      wait_done();
      chk("R1 enable header", last_frame, exp_frame(2'd2, 6'd0));
      chk("R7 enable bit count", seg_edges, 11);

      // R4 R5 write with ready
      issue(2'd1, 6'd5, 16'hA5C3, 1'b0, 16'h0, 1'b0);
      wait_done();
      chk("R1 write header", last_frame, exp_frame(2'd1, 6'd5));
      chk("R4 stored word", mem[5], 16'hA5C3);
      chk("R5 ready seen no timeout", timeout_o, 0);

      // R3 reads
      issue(2'd0, 6'd5, 16'h0, 1'b1, 16'hA5C3, 1'b0);
      wait_done();
      chk("R1 read header", last_frame, exp_frame(2'd0, 6'd5));
      chk("R3 read bit count", seg_edges, 27);
      issue(2'd0, 6'd63, 16'h0, 1'b1, 16'h8001, 1'b0);
      wait_done();
      issue(2'd0, 6'd0, 16'h0, 1'b1, 16'hFFFF, 1'b0);
      wait_done();

      // R9 request while busy ignored
      keep2 = mem[2];
      d0 = done_cnt;
      issue(2'd0, 6'd1, 16'h0, 1'b1, 16'h1111, 1'b0);
      repeat (20) @(negedge clk);
      req = 1'b1; cmd = 2'd1; addr = 6'd2; wdata = 16'hDEAD;
      @(negedge clk);
      req = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (200) @(negedge clk);
      chk("R9 one done only", done_cnt - d0, 1);
      chk("R9 still idle", busy_o, 0);
      chk("R9 header unchanged", last_frame, exp_frame(2'd0, 6'd1));
      chk("R9 target word unchanged", mem[2], keep2);

      // R6 timeout
      never_ready = 1'b1;
      issue(2'd1, 6'd9, 16'h1234, 1'b0, 16'h0, 1'b1);
      wait_done();
      never_ready = 1'b0;
      chk("R6 timeout held", timeout_o, 1);

      // R7 forbid programming clears flag (R6)
      issue(2'd3, 6'd0, 16'h0, 1'b0, 16'h0, 1'b0);
      chk("R6 flag cleared on accept", timeout_o, 0);
      wait_done();
      chk("R1 disable header", last_frame, exp_frame(2'd3, 6'd0));
      chk("R7 disable bit count", seg_edges, 11);

      // R2 timing
      chk("R2 high halves seen", hi_count > 50, 1);
      chk("R2 high half length", timing_bad, 0);

      // R10 reset mid-command
      @(negedge clk);
      req = 1'b1; cmd = 2'd1; addr = 6'd3; wdata = 16'h5555;
      @(negedge clk);
      req = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 busy after reset", busy_o, 0);
      chk("R10 pins after reset", {cs, sk, mosi}, 3'b000);
      chk("R10 rdata after reset", rdata_o, 16'h0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 scoreboard drained", sb_q.size(), 0);
      summary();
   end
endmodule